// File: doc/BRIEF.md
# Selectable Word-Length Audio Requantizer

This block shortens a 20-bit two's-complement audio sample to a narrower word for equipment that cannot take the full width. A 2-bit mode input selects one of four treatments. The sample passes through unchanged, it is rounded to 16 bits, or it is truncated to 16 or 18 bits inside a second-order error-feedback loop. That loop shapes the requantization error so its spectrum rises toward high frequencies and stays low where the ear is most sensitive.

Samples arrive with a one-cycle valid strobe and a channel flag: 0 for left, 1 for right. The loop state is kept separately for each channel, so interleaved stereo streams do not disturb each other. The result is registered. It always appears on the full 20-bit output, and every bit below the chosen width reads zero.

Top module: `wl_requant`

## Requirements
- R1: After synchronous reset, out_valid is 0 and out_sample is 0.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. out_sample changes only in that cycle and holds its value otherwise.
- R3: Mode code 01 outputs the input sample unchanged.
- R4: Mode code 00 adds 8 (half of a 16-bit output LSB) to the signed input and then clears bits 3:0. Example: 0x00008 gives 0x00010, and 0xFFFF7 gives 0xFFFF0.
- R5: In mode code 00, a positive input whose rounded value would exceed the largest code gives 0x7FFF0 and never wraps negative.
- R6: Mode code 10 truncates to 16 bits with error feedback. It forms v = x + 2*d1 - d2, where d1 and d2 are the discarded low-bit values of the channel's previous two shaped samples (unsigned, 0..15). The output is v with bits 3:0 cleared, and the new discarded value is v's bits 3:0.
- R7: Mode code 11 does the same as R6 at 18 bits: bits 1:0 are discarded, and the discarded values range over 0..3.
- R8: The sum v is saturated to the range -524288..524287 before truncation. The discarded value is taken from the saturated sum.
- R9: Channel 0 and channel 1 each keep their own d1 and d2 terms. A sample on one channel does not change the other channel's terms.
- R10: In any clock cycle where the mode code differs from the previous cycle's mode code, the stored terms of both channels are cleared. This holds with or without a valid sample. A sample in that cycle uses zero terms. Reset also clears the terms.
- R11: In modes 00 and 10, out_sample bits 3:0 are zero. In mode 11, out_sample bits 1:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_chan | input | 1 | Channel flag: 0 left, 1 right |
| in_sample | input | 20 | Two's-complement input sample |
| mode | input | 2 | Word-length mode code: 00 round16, 01 pass20, 10 shaped16, 11 shaped18 |
| out_valid | output | 1 | High one cycle after an accepted sample |
| out_sample | output | 20 | Requantized sample, with low bits zero below the chosen width |

## Verification
The bench drives inputs at the extremes 0x7FFFF and 0x80000 in every mode.

- A rounder that wraps on overflow would flip the peak to a large negative code.
- A shaper without sum saturation would let the error loop overflow and emit wrong signs.
- Interleaved left and right streams expose any shared error register as a mismatch against the per-channel model.
- A mode change placed in an idle cycle exposes a design that clears state only on valid samples, because the next shaped output would carry stale feedback.

Negative values just below a rounding boundary, such as -9, check that rounding floors toward minus infinity after the offset is added, rather than truncating toward zero.

// File: rtl/wlq_pkg.sv
// Package: shared mode encoding for the word-length requantizer.
// Assumes: the mode code values are fixed by the external control interface.
package wlq_pkg;

    typedef enum logic [1:0] {
        WL_ROUND16 = 2'b00,
        WL_PASS20  = 2'b01,
        WL_SHAPE16 = 2'b10,
        WL_SHAPE18 = 2'b11
    } wl_mode_e;

endpackage

// File: rtl/wlq_round.sv
// Module: wlq_round
// Rounds a signed IN_W-bit word to OUT_W significant bits. It adds half an
// output LSB, clears the dropped bits, and clamps positive overflow to the
// largest representable code.
// Assumes: OUT_W < IN_W. Negative overflow cannot occur because the offset
// is positive.
module wlq_round #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0] din,
    output logic [IN_W-1:0] dout
);

    localparam int DROP = IN_W - OUT_W;
    localparam logic [IN_W-1:0] HALF = IN_W'(2 ** (DROP - 1));
    localparam logic [IN_W-1:0] KEEP = ~IN_W'(2 ** DROP - 1);
    localparam logic [IN_W-1:0] MAXQ = {1'b0, {(IN_W - 1){1'b1}}} & KEEP;

    logic [IN_W-1:0] sum;
    logic            ovf;

    // Add the half-LSB offset, detect a positive wrap, then clamp or truncate.
    always_comb begin
        sum  = din + HALF;
        ovf  = !din[IN_W-1] && sum[IN_W-1];
        dout = ovf ? MAXQ : (sum & KEEP);
    end

endmodule

// File: rtl/wlq_shaper.sv
// Module: wlq_shaper
// Combinational core of a second-order error-feedback quantizer. It adds
// the weighted discarded bits of the two previous samples (2*d1 - d2) to the
// input, saturates the sum to the IN_W range, truncates to OUT_W bits, and
// returns the new discarded bits.
// Assumes: d1 and d2 are unsigned values smaller than 2**(IN_W-OUT_W),
// zero-extended to ERR_W bits.
module wlq_shaper #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 16,
    parameter int ERR_W = 4
) (
    input  logic [IN_W-1:0]  din,
    input  logic [ERR_W-1:0] d1,
    input  logic [ERR_W-1:0] d2,
    output logic [IN_W-1:0]  dout,
    output logic [ERR_W-1:0] dnew
);

    localparam int DROP = IN_W - OUT_W;
    localparam int SW   = IN_W + 2;
    localparam logic signed [SW-1:0] VMAX = SW'(2 ** (IN_W - 1) - 1);
    localparam logic signed [SW-1:0] VMIN = -VMAX - SW'(1);
    localparam logic [IN_W-1:0] KEEP = ~IN_W'(2 ** DROP - 1);

    logic signed [SW-1:0] xs;
    logic signed [SW-1:0] f1;
    logic signed [SW-1:0] f2;
    logic signed [SW-1:0] v;
    logic        [SW-1:0] vs;

    // Form the feedback sum with enough headroom and clamp it to IN_W range.
    always_comb begin
        xs = SW'($signed(din));
        f1 = SW'({1'b0, d1, 1'b0});
        f2 = SW'({1'b0, d2});
        v  = xs + f1 - f2;
        if (v > VMAX)      vs = VMAX;
        else if (v < VMIN) vs = VMIN;
        else               vs = v;
    end

    // Split the clamped sum into the kept word and the discarded remainder.
    always_comb begin
        dout = vs[IN_W-1:0] & KEEP;
        dnew = ERR_W'(vs[DROP-1:0]);
    end

    // The clamped sum must fit IN_W signed bits (R8).
    always_comb begin
        assert_sum_in_range_R8: assert (vs[SW-1:IN_W-1] == '0 || vs[SW-1:IN_W-1] == '1)
            else $error("clamped feedback sum exceeds input range");
    end

endmodule

// File: rtl/wlq_err_store.sv
// Module: wlq_err_store
// Holds the two most recent discarded-bit terms for each channel. A write
// shifts the channel's newest term into the older slot. A clear zeroes every
// channel. When a write and a clear come together, the written channel keeps
// only the new term.
// Assumes: the reading channel equals the writing channel in any cycle.
module wlq_err_store #(
    parameter int ERR_W = 4,
    parameter int NCH   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr,
    input  logic [$clog2(NCH)-1:0] ch,
    input  logic [ERR_W-1:0]       wr_d,
    output logic [ERR_W-1:0]       e1,
    output logic [ERR_W-1:0]       e2
);

    localparam int CH_W = $clog2(NCH);

    logic [ERR_W-1:0] d1_q [NCH];
    logic [ERR_W-1:0] d2_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // Update this channel's two error terms on reset, write or clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d1_q[g] <= '0;
                d2_q[g] <= '0;
            end else if (wr && ch == CH_W'(g)) begin
                d2_q[g] <= clr ? '0 : d1_q[g];
                d1_q[g] <= wr_d;
            end else if (clr) begin
                d1_q[g] <= '0;
                d2_q[g] <= '0;
            end
        end

        assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !wr) |=> (d1_q[g] == '0 && d2_q[g] == '0))
            else $error("error terms not cleared");

        assert_chan_isolate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && (!wr || ch != CH_W'(g))) |=> ($stable(d1_q[g]) && $stable(d2_q[g])))
            else $error("channel terms changed without own write");
    end

    // Present the selected channel's terms to the datapath.
    always_comb begin
        e1 = d1_q[ch];
        e2 = d2_q[ch];
    end

endmodule

// File: rtl/wl_requant.sv
// Module: wl_requant
// Top of the selectable word-length requantizer. Each valid sample passes
// through unchanged, is rounded to NARROW_W bits, or is truncated to
// NARROW_W or MID_W bits inside an error-feedback loop, as the mode code
// selects. The result is registered one cycle after the strobe.
// Assumes: the mode code is sampled every cycle, and a change from the
// previous cycle clears all loop state.
module wl_requant #(
    parameter int IN_W     = 20,
    parameter int NARROW_W = 16,
    parameter int MID_W    = 18,
    parameter int NCH      = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [$clog2(NCH)-1:0] in_chan,
    input  logic [IN_W-1:0]        in_sample,
    input  logic [1:0]             mode,
    output logic                   out_valid,
    output logic [IN_W-1:0]        out_sample
);

    import wlq_pkg::*;

    localparam int ERR_W  = IN_W - NARROW_W;
    localparam int NSHAPE = 2;

    wl_mode_e          mode_e;
    wl_mode_e          mode_q;
    logic              mode_chg;
    logic              shaping;
    logic [ERR_W-1:0]  st_e1;
    logic [ERR_W-1:0]  st_e2;
    logic [ERR_W-1:0]  use_e1;
    logic [ERR_W-1:0]  use_e2;
    logic [IN_W-1:0]   rnd_out;
    logic [IN_W-1:0]   shp_out [NSHAPE];
    logic [ERR_W-1:0]  shp_d   [NSHAPE];
    logic [ERR_W-1:0]  wr_d;
    logic [IN_W-1:0]   nxt;

    assign mode_e = wl_mode_e'(mode);

    // Remember the previous cycle's mode to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= WL_PASS20;
        else        mode_q <= mode_e;
    end

    // Decode the mode change and substitute zero terms in a change cycle.
    always_comb begin
        mode_chg = (mode_e != mode_q);
        shaping  = (mode_e == WL_SHAPE16) || (mode_e == WL_SHAPE18);
        use_e1   = mode_chg ? '0 : st_e1;
        use_e2   = mode_chg ? '0 : st_e2;
        wr_d     = (mode_e == WL_SHAPE18) ? shp_d[1] : shp_d[0];
    end

    wlq_err_store #(.ERR_W(ERR_W), .NCH(NCH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_chg),
        .wr    (in_valid && shaping),
        .ch    (in_chan),
        .wr_d  (wr_d),
        .e1    (st_e1),
        .e2    (st_e2)
    );

    wlq_round #(.IN_W(IN_W), .OUT_W(NARROW_W)) u_round (
        .din  (in_sample),
        .dout (rnd_out)
    );

    for (genvar k = 0; k < NSHAPE; k++) begin : g_shape
        localparam int OW = (k == 0) ? NARROW_W : MID_W;
        wlq_shaper #(.IN_W(IN_W), .OUT_W(OW), .ERR_W(ERR_W)) u_shaper (
            .din  (in_sample),
            .d1   (use_e1),
            .d2   (use_e2),
            .dout (shp_out[k]),
            .dnew (shp_d[k])
        );
    end

    // Pick the result for the active mode.
    always_comb begin
        case (mode_e)
            WL_ROUND16: nxt = rnd_out;
            WL_PASS20:  nxt = in_sample;
            WL_SHAPE16: nxt = shp_out[0];
            WL_SHAPE18: nxt = shp_out[1];
            default:    nxt = in_sample;
        endcase
    end

    // Register the output word and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= nxt;
        end
    end

    assert_strobe_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("missing output strobe");

    assert_no_spurious_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sample))) else $error("output moved without sample");

    assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01) |=> out_sample == $past(in_sample))
        else $error("pass mode altered sample");

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00 && !in_sample[IN_W-1]) |=> !out_sample[IN_W-1])
        else $error("rounding wrapped negative");

    assert_low_zero16_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode[0]) |=> out_sample[IN_W-NARROW_W-1:0] == '0)
        else $error("16-bit low bits not zero");

    assert_low_zero18_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b11) |=> out_sample[IN_W-MID_W-1:0] == '0)
        else $error("18-bit low bits not zero");

endmodule

// File: tb/wl_requant_test.sv
module wl_requant_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [0:0]  in_chan = '0;
    logic [19:0] in_sample = '0;
    logic [1:0]  mode = 2'b01;
    logic        out_valid;
    logic [19:0] out_sample;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int          md1 [2];
    int          md2 [2];
    logic [1:0]  mprev;
    logic [19:0] last_out;

    always #2 clk = ~clk;

    wl_requant uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .mode(mode), .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic void chk(string tag, logic [19:0] act, logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
        end
    endfunction

    // Reference model of the requirements; updates model state each cycle.
    function automatic logic [19:0] model(bit v, bit ch, logic [19:0] x, logic [1:0] m);
        int xs, s, d, q, drop;
        if (m != mprev) begin
            md1[0] = 0; md1[1] = 0; md2[0] = 0; md2[1] = 0;
        end
        mprev = m;
        if (!v) return last_out;
        xs = int'($signed(x));
        case (m)
            2'b01: return x;
            2'b00: begin
                s = xs + 8;
                if (s > 524287) s = 524287;
                return 20'(s & ~15);
            end
            default: begin
                drop = (m == 2'b11) ? 2 : 4;
                s = xs + 2 * md1[ch] - md2[ch];
                if (s > 524287) s = 524287;
                if (s < -524288) s = -524288;
                q = s & ~((1 << drop) - 1);
                d = s - q;
                md2[ch] = md1[ch];
                md1[ch] = d;
                return 20'(q);
            end
        endcase
    endfunction

    task automatic step(bit v, bit ch, logic [19:0] x, logic [1:0] m, string tag);
        logic [19:0] exp;
        @(negedge clk);
        in_valid = v; in_chan = ch; in_sample = x; mode = m;
        exp = model(v, ch, x, m);
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== v) begin
            errors++;
            $display("FAIL R2: out_valid actual=%0b expected=%0b", out_valid, v);
        end
        chk(tag, out_sample, exp);
        if (v && m == 2'b11) chk("R11", {18'd0, out_sample[1:0]}, 20'd0);
        else if (v && !m[0]) chk("R11", {16'd0, out_sample[3:0]}, 20'd0);
        last_out = exp;
    endtask

    function automatic string tag_for(logic [1:0] m);
        case (m)
            2'b00: return "R4";
            2'b01: return "R3";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        logic [1:0] rm;
        md1[0] = 0; md1[1] = 0; md2[0] = 0; md2[1] = 0;
        mprev = 2'b01; last_out = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid actual=%0b expected=0", out_valid);
        end
        chk("R1", out_sample, 20'h00000);

        step(1, 0, 20'h12345, 2'b01, "R3");
        step(0, 0, 20'h00000, 2'b01, "R2");
        step(1, 0, 20'h00008, 2'b00, "R4");
        chk("R4", out_sample, 20'h00010);
        step(1, 0, 20'h00007, 2'b00, "R4");
        step(1, 1, 20'hFFFF8, 2'b00, "R4");
        step(1, 1, 20'hFFFF7, 2'b00, "R4");
        chk("R4", out_sample, 20'hFFFF0);
        step(1, 0, 20'h7FFFF, 2'b00, "R5");
        chk("R5", out_sample, 20'h7FFF0);
        step(1, 0, 20'h7FFF9, 2'b00, "R5");

        for (int i = 0; i < 4; i++) step(1, 0, 20'h00005, 2'b10, "R6");
        for (int i = 0; i < 6; i++) step(1, i[0], 20'h00003 + 20'(i), 2'b10, "R9");
        for (int i = 0; i < 4; i++) step(1, 0, 20'h7FFFF, 2'b10, "R8");
        for (int i = 0; i < 4; i++) step(1, 1, 20'h80000, 2'b10, "R8");
        for (int i = 0; i < 5; i++) step(1, i[0], 20'h00001, 2'b11, "R7");
        step(0, 0, 20'h0, 2'b01, "R10");
        step(1, 0, 20'h00001, 2'b11, "R10");
        chk("R10", out_sample, 20'h00000);
        step(1, 0, 20'h00001, 2'b11, "R10");
        chk("R10", out_sample, 20'h00000);

        void'($urandom(32'h5EED));
        rm = 2'b10;
        for (int i = 0; i < 4000; i++) begin
            logic [19:0] x;
            if ($urandom_range(63) == 0) rm = 2'($urandom_range(3));
            case ($urandom_range(15))
                0: x = 20'h7FFFF;
                1: x = 20'h80000;
                2: x = 20'h7FFF8;
                3: x = 20'hFFFF8;
                default: x = 20'($urandom);
            endcase
            step($urandom_range(3) != 0, 1'($urandom_range(1)), x, rm, tag_for(rm));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule